// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is the device-side logic of a word-organised serial EEPROM. A host frames each command with an active-low chip select and clocks it in on a serial clock and data line. The block decodes four commands: read, write, write-enable and write-disable. It keeps an internal array of 16-bit words, with the depth set by the address width, and answers reads on a serial data output that is released (output enable low) whenever it is not driving. Writes run a self-timed programming interval of a configurable number of system clocks. A ready/busy output is low for that interval, and the same status can also be requested on the data output.

All serial inputs are oversampled by the system clock through two-stage synchronizers. Edges of the serial clock are found from the synchronized copy, so each serial-clock level must last at least four system clocks. A write-control input aborts writes only; it has no effect on the other commands. An aborted programming interval leaves the target word erased to all ones.

Top module: `eeprom_cmd_slave`

## Requirements
- R1: After reset, rdy is 1, dout_oe is 0, writes are disabled, and every word of the array reads 0xFFFF.
- R2: DI is captured on rising edges of SK. DO changes only after falling edges of SK. Each SK level is held for at least four clk cycles.
- R3: A frame opens with the bits 1,0,1,0 in that order, followed by an opcode and an address sent LSB first. With ADDR_W=9 the opcode bits in sending order are 1,0,0 for read and 0,1,0 for write. With ADDR_W=10 they are 1,0 for read and 0,1 for write. A frame with any other start pattern or opcode is ignored until CS_n returns high.
- R4: Write-enable is 1,0,1,0,0,0,1,1 and write-disable is 1,0,1,0,0,0,0,0, each followed by 8 ignored bits. The enable state persists until write-disable or reset.
- R5: For a read, D0 of the addressed word is driven after the 16th SK falling edge, and the remaining bits follow LSB first, one per falling edge. Continued clocking outputs the next word every 16 clocks, and the address wraps from the top word to word 0.
- R6: A write frame carries 16 data bits LSB first, 32 clocks in total. When writes are enabled, rdy goes low just after the 32nd rising edge and stays low for PROG_CYC clocks. After that the word holds the data.
- R7: A write issued while writes are disabled leaves the array unchanged and keeps rdy high.
- R8: WC high at any point during write entry cancels the write: no busy, word unchanged. WC has no effect on read, write-enable or write-disable.
- R9: WC high during the programming interval ends it at once (rdy returns high) and leaves the target word at 0xFFFF.
- R10: While rdy is low, no command is accepted. A frame started during that time is ignored until CS_n goes high.
- R11: CS_n high cancels a read and releases DO (dout_oe 0). A new frame needs CS_n to go high and then low.
- R12: After a write has started, taking CS_n low while SK is low makes the block drive DO with the ready/busy status until CS_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command, address and data input |
| wc | input | 1 | Write control; high aborts writes |
| dout | output | 1 | Serial data or status output |
| dout_oe | output | 1 | High while dout is driven, low for high impedance |
| rdy | output | 1 | High when ready, low while programming |

## Verification
Reads are tried from a lone address, across a word boundary, and across the top of the array. These cases separate correct bit order and address stepping from an off-by-one in the bit pointer or a missing wrap. Writes are issued in four conditions: enabled, disabled, with WC pulsed during entry, and with WC pulsed during programming. Each leaves a different signature in rdy and in the word read back. Frames with a bad start pattern, frames sent while busy, and reads cut short by CS_n show that the decoder drops anything it must not act on. A status probe taken while busy and again after completion shows DO following the ready state.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    CMD_BAD, CMD_READ, CMD_WRITE, CMD_WEN, CMD_WDS
  } cmd_e;

  typedef enum logic [2:0] {
    F_IDLE, F_HDR, F_WDAT, F_READ, F_SKIP
  } fstate_e;

  // h[i] is the i-th bit received on the serial line
  function automatic cmd_e decode_frame(input logic [15:0] h, input int opw);
    logic tail_zero;
    tail_zero = 1'b1;
    for (int i = 2; i < 4; i++)
      if (i < opw && h[4+i]) tail_zero = 1'b0;
    if (h[3:0] != 4'b0101) return CMD_BAD;
    if (h[4] && !h[5] && tail_zero) return CMD_READ;
    if (!h[4] && h[5] && tail_zero) return CMD_WRITE;
    if (h[7:4] == 4'b1100) return CMD_WEN;
    if (h[7:4] == 4'b0000) return CMD_WDS;
    return CMD_BAD;
  endfunction

  function automatic int next_word(input int a, input int depth);
    return (a == depth - 1) ? 0 : a + 1;
  endfunction

endpackage

// File: rtl/eep_insync.sv
module eep_insync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1, s2, s3;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g] <= RST[g];
        s2[g] <= RST[g];
        s3[g] <= RST[g];
      end else begin
        s1[g] <= async_i[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
    end
    assign rise_o[g] = s2[g] & ~s3[g];
    assign fall_o[g] = ~s2[g] & s3[g];
  end

  assign sync_o = s2;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [15:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [15:0]       rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int OPW = 12 - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              di_s,
  input  logic              wc_s,
  input  logic              busy,
  input  logic [15:0]       rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  output logic              rd_oe,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data
);
  fstate_e     st;
  logic [3:0]  cnt, ptr;
  logic [15:0] hdr;
  logic        en_q, wc_hit;
  logic [15:0] full;
  cmd_e        cmd;
  logic [ADDR_W-1:0] f_addr;

  assign full   = {di_s, hdr[14:0]};
  assign cmd    = decode_frame(full, OPW);
  assign f_addr = full[15 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; cnt <= '0; ptr <= '0; hdr <= '0;
      en_q <= 1'b0; wc_hit <= 1'b0; rd_addr <= '0; rd_bit <= 1'b0;
      rd_oe <= 1'b0; wr_go <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_go <= 1'b0;
      if (cs_n_s) begin
        st <= F_IDLE; cnt <= '0; rd_oe <= 1'b0; wc_hit <= 1'b0;
      end else begin
        if (wc_s && (st == F_IDLE || st == F_HDR || st == F_WDAT)) wc_hit <= 1'b1;
        unique case (st)
          F_IDLE: begin
            if (busy) st <= F_SKIP;
            else if (sk_rise) begin
              hdr[0] <= di_s; cnt <= 4'd1; st <= F_HDR;
            end
          end
          F_HDR: if (sk_rise) begin
            hdr[cnt] <= di_s;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              unique case (cmd)
                CMD_READ:  begin rd_addr <= f_addr; ptr <= '0; st <= F_READ; end
                CMD_WRITE: begin wr_addr <= f_addr; st <= F_WDAT; end
                CMD_WEN:   begin en_q <= 1'b1; st <= F_SKIP; end
                CMD_WDS:   begin en_q <= 1'b0; st <= F_SKIP; end
                default:   st <= F_SKIP;
              endcase
            end
          end
          F_WDAT: if (sk_rise) begin
            wr_data[cnt] <= di_s;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              wr_go <= en_q && !wc_hit && !wc_s;
              st <= F_SKIP;
            end
          end
          F_READ: if (sk_fall) begin
            rd_bit <= rd_word[ptr];
            rd_oe  <= 1'b1;
            ptr    <= ptr + 4'd1;
            if (ptr == 4'd15) rd_addr <= ADDR_W'(next_word(int'(rd_addr), DEPTH));
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a programming launch only ever comes from the enabled state
  a_r7_go_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> en_q);
  // R11: chip select high releases the read output on the next cycle
  a_r11_cancel_read: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !rd_oe);
  // R10: no frame entry while programming is in progress
  a_r10_no_entry_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == F_IDLE && !cs_n_s) |=> st != F_HDR);
endmodule

// File: rtl/eep_prog.sv
module eep_prog #(
  parameter int ADDR_W = 9,
  parameter int PROG_CYC = 64,
  localparam int CW = $clog2(PROG_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       data,
  input  logic              wc_s,
  input  logic              cs_n_s,
  input  logic              cs_fall,
  input  logic              sk_s,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              stat_on
);
  logic [CW-1:0] tcnt;
  logic [15:0]   d_q;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tcnt <= '0; d_q <= '0; mem_addr <= '0;
      mem_we <= 1'b0; mem_wdata <= '0; armed <= 1'b0; stat_on <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (go) begin
        busy <= 1'b1; tcnt <= '0; mem_addr <= addr; d_q <= data; armed <= 1'b1;
      end else if (busy) begin
        if (wc_s) begin
          busy <= 1'b0; mem_we <= 1'b1; mem_wdata <= 16'hFFFF;
        end else if (tcnt == CW'(PROG_CYC - 1)) begin
          busy <= 1'b0; mem_we <= 1'b1; mem_wdata <= d_q;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (cs_n_s) begin
        stat_on <= 1'b0;
        if (!busy && !go) armed <= 1'b0;
      end else if (cs_fall && !sk_s && armed) begin
        stat_on <= 1'b1;
      end
    end
  end

  // R6: launching a write raises busy
  a_r6_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  // R6: the interval never outlasts its configured length
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tcnt < CW'(PROG_CYC));
  // R9: write control ends programming at once
  a_r9_wc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wc_s && !go) |=> !busy);
  // R6: the array is written only as the interval closes
  a_r6_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy && $past(busy));
endmodule

// File: rtl/eeprom_cmd_slave.sv
module eeprom_cmd_slave #(
  parameter int ADDR_W = 9,
  parameter int PROG_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sk,
  input  logic di,
  input  logic wc,
  output logic dout,
  output logic dout_oe,
  output logic rdy
);
  logic [3:0] s_lvl, s_rise, s_fall;
  logic              busy, rd_bit, rd_oe, wr_go, mem_we, stat_on;
  logic [ADDR_W-1:0] rd_addr, wr_addr, mem_addr;
  logic [15:0]       rd_word, wr_data, mem_wdata;

  // vector order: {wc, di, sk, cs_n}
  eep_insync #(.N(4), .RST(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({wc, di, sk, cs_n}),
    .sync_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall));

  eep_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(s_lvl[0]), .sk_rise(s_rise[1]),
    .sk_fall(s_fall[1]), .di_s(s_lvl[2]), .wc_s(s_lvl[3]), .busy(busy),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_bit(rd_bit), .rd_oe(rd_oe),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data));

  eep_prog #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .addr(wr_addr), .data(wr_data),
    .wc_s(s_lvl[3]), .cs_n_s(s_lvl[0]), .cs_fall(s_fall[0]), .sk_s(s_lvl[1]),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stat_on(stat_on));

  eep_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_word));

  assign rdy     = ~busy;
  assign dout_oe = stat_on | rd_oe;
  assign dout    = stat_on ? ~busy : rd_bit;

  // R12: status display and read data never drive DO together
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    stat_on |-> !rd_oe);
endmodule

// File: tb/sim_eeprom_cmd_slave.sv
module sim_eeprom_cmd_slave;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PROG = 600;

  logic clk = 0, rst_n = 0, cs_n = 1, sk = 0, di = 0, wc = 0;
  logic dout, dout_oe, rdy;
  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [DEPTH];

  always #2 clk = ~clk;

  eeprom_cmd_slave #(.ADDR_W(AW), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .di(di), .wc(wc),
    .dout(dout), .dout_oe(dout_oe), .rdy(rdy));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sk_cycle(input logic b, output logic so, output logic soe);
    di = b;
    repeat (8) @(negedge clk);
    so = dout; soe = dout_oe;
    sk = 1;
    repeat (8) @(negedge clk);
    sk = 0;
  endtask

  task automatic cs_lo(); cs_n = 0; repeat (8) @(negedge clk); endtask
  task automatic cs_hi(); cs_n = 1; repeat (8) @(negedge clk); endtask

  // bit i of the result is the i-th bit sent
  function automatic logic [15:0] hdr(input int kind, input int a);
    logic [15:0] h;
    h = '0;
    h[3:0] = 4'b0101;
    case (kind)
      0: begin h[4] = 1; h[15:7] = a[8:0]; end        // read
      1: begin h[5] = 1; h[15:7] = a[8:0]; end        // write
      2: h[7:4] = 4'b1100;                             // enable
      3: h[7:4] = 4'b0000;                             // disable
      default: begin h[3:0] = 4'b0111; h[4] = 1; end   // bad start
    endcase
    return h;
  endfunction

  task automatic send16(input logic [15:0] v, output logic any_oe);
    logic so, soe;
    any_oe = 0;
    for (int i = 0; i < 16; i++) begin sk_cycle(v[i], so, soe); any_oe |= soe; end
  endtask

  task automatic write_word(input int a, input logic [15:0] d, input int wc_bit);
    logic so, soe;
    cs_lo();
    for (int i = 0; i < 32; i++) begin
      if (i == wc_bit) wc = 1;
      sk_cycle(i < 16 ? hdr(1, a)[i] : d[i-16], so, soe);
      wc = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd16(input int kind);
    logic x;
    cs_lo(); send16(hdr(kind, 0), x); cs_hi();
  endtask

  task automatic read_chk(input string tag, input int a, input int nw);
    logic so, soe, x, all_oe;
    logic [15:0] w;
    cs_lo();
    send16(hdr(0, a), x);
    for (int k = 0; k < nw; k++) begin
      all_oe = 1;
      for (int b = 0; b < 16; b++) begin sk_cycle(0, so, soe); w[b] = so; all_oe &= soe; end
      chk({tag, " word"}, w, mdl[(a + k) % DEPTH]);
      chk({tag, " oe"}, 16'(all_oe), 16'd1);
    end
    cs_hi();
    chk("R11 oe released after CS high", 16'(dout_oe), 16'd0);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic so, soe, x;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 rdy after reset", 16'(rdy), 16'd1);
    chk("R1 oe after reset", 16'(dout_oe), 16'd0);
    read_chk("R1 R5 erased word", 3, 1);

    // R7: write while disabled
    write_word(5, 16'hA55A, -1);
    chk("R7 rdy stays high", 16'(rdy), 16'd1);
    cs_hi();
    read_chk("R7 word unchanged", 5, 1);

    // R4 enable, R6 timed write
    cmd16(2);
    write_word(5, 16'hA55A, -1);
    chk("R6 busy after 32nd edge", 16'(rdy), 16'd0);
    wait_rdy(n);
    chk("R6 interval length lower", 16'(n >= PROG - 12), 16'd1);
    chk("R6 interval length upper", 16'(n <= PROG), 16'd1);
    mdl[5] = 16'hA55A;
    cs_hi();
    read_chk("R2 R6 written word", 5, 1);

    write_word(6, 16'h1234, -1); wait_rdy(n); mdl[6] = 16'h1234; cs_hi();
    read_chk("R5 sequential", 5, 2);
    write_word(511, 16'h0F0F, -1); wait_rdy(n); mdl[511] = 16'h0F0F; cs_hi();
    read_chk("R5 wrap to zero", 511, 2);

    // R8: WC during entry
    write_word(8, 16'h3333, 20);
    chk("R8 no busy after WC in entry", 16'(rdy), 16'd1);
    cs_hi();
    read_chk("R8 word unchanged", 8, 1);
    wc = 1;
    read_chk("R8 read ignores WC", 5, 1);
    wc = 0;

    // R9: WC during programming
    write_word(7, 16'h0000, -1); wait_rdy(n); mdl[7] = 16'h0000; cs_hi();
    write_word(7, 16'h1111, -1);
    chk("R9 busy before abort", 16'(rdy), 16'd0);
    wc = 1; repeat (8) @(negedge clk); wc = 0;
    chk("R9 rdy after abort", 16'(rdy), 16'd1);
    mdl[7] = 16'hFFFF;
    cs_hi();
    read_chk("R9 aborted word erased", 7, 1);

    // R12: status on DO
    write_word(9, 16'h5555, -1); cs_hi();
    cs_n = 0; repeat (8) @(negedge clk);
    chk("R12 status oe while busy", 16'(dout_oe), 16'd1);
    chk("R12 status shows busy", 16'(dout), 16'd0);
    wait_rdy(n); repeat (6) @(negedge clk);
    chk("R12 status shows ready", 16'(dout), 16'd1);
    mdl[9] = 16'h5555;
    cs_hi();
    chk("R12 status released", 16'(dout_oe), 16'd0);

    // R10: frame during busy ignored
    write_word(20, 16'h1111, -1); cs_hi();
    write_word(21, 16'h2222, -1);
    wait_rdy(n); mdl[20] = 16'h1111; cs_hi();
    read_chk("R10 busy frame dropped", 21, 1);
    read_chk("R10 first write kept", 20, 1);

    // R3: bad start pattern
    cs_lo(); send16(hdr(9, 5), x); send16(16'h0, x);
    chk("R3 bad frame no output", 16'(x), 16'd0);
    cs_hi();

    // R11: cancelled read then fresh read
    cs_lo(); send16(hdr(0, 5), x);
    for (int i = 0; i < 4; i++) sk_cycle(0, so, soe);
    cs_hi();
    chk("R11 cancel releases DO", 16'(dout_oe), 16'd0);
    read_chk("R11 fresh read after cancel", 5, 1);

    // R4: disable then write
    cmd16(3);
    write_word(10, 16'h7777, -1);
    chk("R4 no busy after disable", 16'(rdy), 16'd1);
    cs_hi();
    read_chk("R4 word unchanged after disable", 10, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule